// File: doc/BRIEF.md
# Sequential Signed Shift-Add Multiplier

This block multiplies two signed (two's-complement) operands of `WIDTH` bits each and returns the full signed product of `2*WIDTH` bits. It works through one multiplier bit per clock cycle, starting from the least significant bit. It trades latency for area: the only adder is `WIDTH+1` bits wide, where a single-cycle array would need `WIDTH` rows of adders.

The multiplicand is widened by one guard sign bit. Partial sums build up in an upper accumulator that is `WIDTH+1` bits wide. After every step the accumulator shifts right by one place. The guard bit is copied into the vacated top position, and the bit that falls off the bottom enters a lower register. Bits in the lower register are settled once they arrive. A multiplier bit below the sign position adds the multiplicand when it is 1. The sign position subtracts the multiplicand when it is 1, so negative multipliers need no special pre-processing.

A caller pulses `start` while the block is idle, then waits for the one-cycle `done` pulse and reads `product`.

Top module: `seq_mul`

## Requirements
- R1: After reset, `busy`, `done` and `product` are all zero.
- R2: A `start` seen at a rising edge while `busy` is low captures both operands at that edge, and `busy` is high from the next cycle on.
- R3: `busy` stays high for exactly `WIDTH` cycles. `done` rises at the same edge where `busy` falls and stays high for exactly one cycle.
- R4: While `done` is high, `product` equals the signed product of the captured operands, as a `2*WIDTH`-bit two's-complement value.
- R5: A multiplier whose sign bit is 1 yields the correct negative or positive product. This includes the most negative value times itself, for example 6 × -5 = -30 and -8 × -8 = 64 at a width of 4.
- R6: A `start` asserted while `busy` is high is ignored. Changes to the operand inputs after the accepting edge do not affect the result or the cycle count.
- R7: After `done`, `product` holds its value until the next accepted `start`.
- R8: A zero operand on either side gives a zero product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a new multiplication (accepted only when idle) |
| multiplicand | input | WIDTH | Signed multiplicand, captured on the accepting edge |
| multiplier | input | WIDTH | Signed multiplier, captured on the accepting edge |
| busy | output | 1 | High while the multiplication is in progress |
| done | output | 1 | One-cycle pulse when the product is ready |
| product | output | 2*WIDTH | Signed product |

## Verification
The bench builds the block with `WIDTH = 4`. At that width all 256 operand pairs can be run exhaustively, so every combination of signs, zero, the most negative value and the most positive value is covered. Seeded random noise on `start` and on the operand inputs during `busy` exercises the ignore rule. The bench also checks that the product holds during the idle gaps after each result.

// File: rtl/seq_mul_pkg.sv
package seq_mul_pkg;
  // Strobes from the control unit to the datapath.
  typedef struct packed {
    logic load;      // capture operands, clear accumulators
    logic step;      // process one multiplier bit
    logic lastStep;  // current bit is the multiplier sign bit
  } mulStrobes_t;
endpackage

// File: rtl/seq_mul_ctrl.sv
module seq_mul_ctrl
  import seq_mul_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  output logic        busy,
  output logic        done,
  output mulStrobes_t strobes
);
  localparam int CW = (WIDTH > 2) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  logic [CW-1:0] bitCnt;
  logic          atLast;

  assign atLast = (bitCnt == LAST);

  always_comb begin
    strobes.load     = start && !busy;
    strobes.step     = busy;
    strobes.lastStep = busy && atLast;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      bitCnt <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy   <= 1'b1;
          bitCnt <= '0;
        end
      end else if (atLast) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> (busy && bitCnt == '0));

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R3
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R6
  busy_advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !atLast) |=> (busy && bitCnt == $past(bitCnt) + 1'b1));

  // R3
  finish_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && atLast) |=> (done && !busy));
endmodule

// File: rtl/seq_mul_dp.sv
module seq_mul_dp
  import seq_mul_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  mulStrobes_t          strobes,
  input  logic [WIDTH-1:0]     multiplicand,
  input  logic [WIDTH-1:0]     multiplier,
  output logic [2*WIDTH-1:0]   product
);
  localparam int AW = WIDTH + 1;

  logic [AW-1:0]    accHi;     // upper accumulator with guard sign bit
  logic [WIDTH-1:0] accLo;     // settled low product bits
  logic [AW-1:0]    mcandExt;  // sign-extended multiplicand
  logic [WIDTH-1:0] mplierSh;  // multiplier, consumed from bit 0
  logic [AW-1:0]    partial;
  logic [AW-1:0]    sum;

  always_comb begin
    partial = mplierSh[0] ? mcandExt : '0;
    sum     = strobes.lastStep ? (accHi - partial) : (accHi + partial);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accHi    <= '0;
      accLo    <= '0;
      mcandExt <= '0;
      mplierSh <= '0;
    end else if (strobes.load) begin
      accHi    <= '0;
      accLo    <= '0;
      mcandExt <= {multiplicand[WIDTH-1], multiplicand};
      mplierSh <= multiplier;
    end else if (strobes.step) begin
      accHi    <= {sum[AW-1], sum[AW-1:1]};
      accLo    <= {sum[0], accLo[WIDTH-1:1]};
      mplierSh <= mplierSh >> 1;
    end
  end

  assign product = {accHi[WIDTH-1:0], accLo};

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.load && !strobes.step) |=> $stable(product));

  // R4
  low_settled_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.step |=> (accLo[WIDTH-2:0] == $past(accLo[WIDTH-1:1])));

  // R6
  operand_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.step && !strobes.load) |=> $stable(mcandExt));
endmodule

// File: rtl/seq_mul.sv
module seq_mul
  import seq_mul_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [WIDTH-1:0]     multiplicand,
  input  logic [WIDTH-1:0]     multiplier,
  output logic                 busy,
  output logic                 done,
  output logic [2*WIDTH-1:0]   product
);
  mulStrobes_t strobes;

  seq_mul_ctrl #(.WIDTH(WIDTH)) ctrlU (
    .clk(clk), .rstN(rstN), .start(start),
    .busy(busy), .done(done), .strobes(strobes)
  );

  seq_mul_dp #(.WIDTH(WIDTH)) dpU (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .multiplicand(multiplicand), .multiplier(multiplier),
    .product(product)
  );
endmodule

// File: tb/seq_mul_test.sv
module seq_mul_test;
  localparam int W = 4;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           start = 1'b0;
  logic [W-1:0]   mcand = '0;
  logic [W-1:0]   mplier = '0;
  logic           busy;
  logic           done;
  logic [2*W-1:0] product;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  seq_mul #(.WIDTH(W)) uut (
    .clk(clk), .rstN(rstN), .start(start),
    .multiplicand(mcand), .multiplier(mplier),
    .busy(busy), .done(done), .product(product)
  );

  function automatic logic [2*W-1:0] expProd(input logic [W-1:0] a, input logic [W-1:0] b);
    longint sa, sb, p;
    sa = a[W-1] ? longint'(a) - (longint'(1) << W) : longint'(a);
    sb = b[W-1] ? longint'(b) - (longint'(1) << W) : longint'(b);
    p  = sa * sb;
    return p[2*W-1:0];
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic runOp(input logic [W-1:0] a, input logic [W-1:0] b, input bit noisy, input string req);
    logic [2*W-1:0] want;
    logic [2*W-1:0] held;
    int cyc;
    want = expProd(a, b);
    @(negedge clk);
    start = 1'b1; mcand = a; mplier = b;
    @(negedge clk);
    check(busy == 1'b1, "R2 busy after start", busy, 1);
    cyc = 0;
    while (busy && cyc < 3 * W) begin
      cyc++;
      if (noisy) begin
        start  = 1'(($urandom % 2));
        mcand  = W'($urandom);
        mplier = W'($urandom);
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    check(cyc == W, noisy ? "R6 cycle count under noise" : "R3 busy length", cyc, W);
    check(done == 1'b1, "R3 done at end", done, 1);
    check(product == want, req, product, want);
    held = product;
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, "R3 done single pulse", {busy, done}, 0);
    check(product == held, "R7 product hold", product, held);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && done == 1'b0 && product == '0, "R1 reset state",
          {busy, done, product}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(busy == 1'b0 && product == '0, "R1 idle after reset", {busy, product}, 0);

    void'($urandom(32'd1234));
    runOp(4'd6, 4'hB, 1'b0, "R5 6 x -5");
    runOp(4'h8, 4'h8, 1'b0, "R5 -8 x -8");
    runOp(4'h7, 4'h8, 1'b0, "R5 7 x -8");
    runOp(4'h0, 4'hF, 1'b0, "R8 zero multiplicand");
    runOp(4'hF, 4'h0, 1'b0, "R8 zero multiplier");
    runOp(4'h7, 4'h7, 1'b1, "R6 7 x 7 with noise");

    for (int i = 0; i < 256; i++)
      runOp(W'(i >> 4), W'(i), ($urandom % 4) == 0, "R4 exhaustive product");

    repeat (3) @(negedge clk);
    check(product == expProd(4'hF, 4'hF) && !busy, "R7 long hold", product,
          expProd(4'hF, 4'hF));
    finished = 1'b1;
  end

  initial begin
    int n;
    n = 0;
    while (!finished && n < 100000) begin
      @(posedge clk);
      n++;
    end
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=finish", n);
    end
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule